// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block is a slave port. Through it, an external 8-bit microcontroller reads and writes a bank of 32 internal byte-wide registers. A static strap input picks how the host bus is wired. In multiplexed style a single 8-bit bus carries the address first, captured when the address-latch strobe falls, and then the data. In separate style the first bus carries only the address and a second 8-bit bus carries the data in both directions. Tri-state pins are modelled as separate output-value and output-enable signals.

The host strobes (two chip selects, address latch, active-low read and write) are asynchronous to the block clock. They pass through synchronisers, and the block acts on their edges. A write lands in the register file about three clocks after the write strobe rises. On the internal side, an engine write port updates registers directly and takes priority over a host write to the same register in the same cycle. Four registers are status registers: 0x0C, 0x0D, 0x1E and 0x1F. When the engine changes the value of one of them, a per-register pending flag is set and the active-low alert output drops. Once the host has read every flagged register, the alert output returns high.

Top module: `hostbus_regport`

## Requirements
- R1: With the strap at 1 (multiplexed), the value on bus A is taken as the address at the falling edge of the address-latch strobe. Host writes take their data from bus A. A read drives the addressed register on bus A with bus_a_oe=1.
- R2: With the strap at 0 (separate), bus A is the address and bus B carries write and read data. A read drives bus B with bus_b_oe=1, and bus_a_oe stays 0.
- R3: The port is selected only while both chip selects are 1. With either one at 0, a write leaves the register unchanged and both output enables stay 0.
- R4: An output enable is 1 only while the port is selected and rd_n is 0. It is 0 when idle and during writes.
- R5: A host write commits on the rising edge of wr_n. The address and data must be steady for two clock samples around that edge. While wr_n is still low, the register keeps its old value.
- R6: An engine write that changes the value of register 0x0C, 0x0D, 0x1E or 0x1F drives alert_n to 0 on the next clock. An engine write of an unchanged value, an engine write to any other register, or a host write does not lower alert_n.
- R7: Each of the four status registers has its own pending flag. A completed host read of that register (rd_n rising) clears its flag. alert_n returns to 1 only when all four flags are clear. Reads of other registers leave the flags unchanged.
- R8: If a host write and an engine write reach the same register in the same cycle, the engine value is stored.
- R9: After reset every register reads 0x00, alert_n is 1 and both output enables are 0.
- R10: In multiplexed style the latched address persists across any number of accesses until the next falling edge of the latch strobe.
- R11: Addresses 0x20 to 0xFF are outside the bank. Writes to them change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | Bus-style strap: 1 multiplexed, 0 separate |
| cs_a_i | input | 1 | Chip select A, active high |
| cs_b_i | input | 1 | Chip select B, active high |
| ale_i | input | 1 | Address-latch strobe, captures on its falling edge |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low, commits on its rising edge |
| bus_a_i | input | 8 | Bus A input: address, or address and data |
| bus_a_o | output | 8 | Bus A read data |
| bus_a_oe | output | 1 | Bus A drive enable |
| bus_b_i | input | 8 | Bus B write data (separate style) |
| bus_b_o | output | 8 | Bus B read data |
| bus_b_oe | output | 1 | Bus B drive enable |
| eng_we_i | input | 1 | Engine write strobe |
| eng_idx_i | input | 5 | Engine register index |
| eng_data_i | input | 8 | Engine write data |
| alert_n_o | output | 1 | Status-change alert, active low |

## Verification
A wrong latched address or a wrong register entry shows up at the next host read: the bus carries the wrong byte on the strobe's first sampled cycle. A write lost to the chip-select or edge logic shows up the same way, one read later. A stuck or mis-cleared pending flag shows at alert_n one clock after the engine write, or about three clocks after the read strobe rises. The bench therefore interleaves engine updates with host reads of status and non-status registers, and it checks alert_n after each one.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_DW    = 8;
  localparam int HB_AW    = 8;
  localparam int HB_IW    = 5;
  localparam int HB_NSTAT = 4;
  localparam int HB_SYNC  = 2;

  // One-hot slot of a status register, zero for ordinary registers.
  function automatic logic [HB_NSTAT-1:0] stat_onehot(input logic [HB_IW-1:0] idx);
    case (idx)
      5'h0C:   return 4'b0001;
      5'h0D:   return 4'b0010;
      5'h1E:   return 4'b0100;
      5'h1F:   return 4'b1000;
      default: return '0;
    endcase
  endfunction

  // A bus address maps onto the bank only when its upper bits are clear.
  function automatic logic idx_in_range(input logic [HB_AW-1:0] a);
    return a[HB_AW-1:HB_IW] == '0;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  // STAGES flops for metastability, one more to expose the previous sample.
  for (genvar i = 0; i <= STAGES; i++) begin : g_st
    logic [W-1:0] r;
    if (i == 0) begin : g_in
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_st[i-1].r;
      end
    end
  end

  assign q      = g_st[STAGES-1].r;
  assign q_prev = g_st[STAGES].r;
endmodule

// File: rtl/hb_access.sv
module hb_access
  import hb_pkg::*;
#(
  parameter int AW = HB_AW,
  parameter int DW = HB_DW,
  parameter int IW = HB_IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_mode,
  input  logic [1:0]    cs_s,
  input  logic [1:0]    cs_p,
  input  logic          ale_s,
  input  logic          ale_p,
  input  logic          rd_s,
  input  logic          rd_p,
  input  logic          wr_s,
  input  logic          wr_p,
  input  logic [AW-1:0] a_s,
  input  logic [AW-1:0] a_p,
  input  logic [DW-1:0] b_s,
  input  logic [DW-1:0] b_p,
  output logic [AW-1:0] lat_addr,
  output logic          host_we,
  output logic [IW-1:0] host_idx,
  output logic [DW-1:0] host_wdata,
  output logic          rd_done,
  output logic [IW-1:0] rd_done_idx
);
  // Edge events, named for the assertions.
  logic sel_ok, ale_fall, wr_rise, rd_rise, bus_steady, acc_ok;
  logic [AW-1:0] acc_addr;

  assign sel_ok     = (&cs_s) && (&cs_p);
  assign ale_fall   = mux_mode && ale_p && !ale_s;
  assign wr_rise    = wr_s && !wr_p;
  assign rd_rise    = rd_s && !rd_p;
  assign bus_steady = (a_s == a_p) && (mux_mode || (b_s == b_p));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_addr <= '0;
    else if (ale_fall) lat_addr <= a_s;
  end

  assign acc_addr    = mux_mode ? lat_addr : a_s;
  assign acc_ok      = sel_ok && bus_steady && idx_in_range(acc_addr);
  assign host_we     = wr_rise && acc_ok;
  assign host_idx    = acc_addr[IW-1:0];
  assign host_wdata  = mux_mode ? DW'(a_s) : b_s;
  assign rd_done     = rd_rise && acc_ok;
  assign rd_done_idx = acc_addr[IW-1:0];

  // R1
  ale_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> lat_addr == $past(a_s));

  // R10
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(lat_addr));
endmodule

// File: rtl/hb_regbank.sv
module hb_regbank
  import hb_pkg::*;
#(
  parameter int DW = HB_DW,
  parameter int IW = HB_IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [IW-1:0]       host_idx,
  input  logic [DW-1:0]       host_wdata,
  input  logic                host_rd_done,
  input  logic [IW-1:0]       host_rd_idx,
  input  logic                eng_we,
  input  logic [IW-1:0]       eng_idx,
  input  logic [DW-1:0]       eng_data,
  input  logic [IW-1:0]       rd_idx,
  output logic [DW-1:0]       rd_data,
  output logic                alert_n
);
  localparam int DEPTH = 1 << IW;

  logic [DEPTH-1:0][DW-1:0] regs;
  logic [HB_NSTAT-1:0]      pend, eng_set, host_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eng_we && eng_idx == IW'(i))        regs[i] <= eng_data;
        else if (host_we && host_idx == IW'(i)) regs[i] <= host_wdata;
      end
    end
  end

  // The engine marks a status slot only when the stored value changes.
  assign eng_set  = (eng_we && regs[eng_idx] != eng_data) ? stat_onehot(eng_idx) : '0;
  assign host_clr = host_rd_done ? stat_onehot(host_rd_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~host_clr) | eng_set;
  end

  assign alert_n = ~|pend;
  assign rd_data = regs[rd_idx];

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we && !eng_we |=> $stable(regs));

  // R6
  alert_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set != '0 |=> !alert_n);

  // R7
  alert_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr != '0) && !eng_we && ((pend & ~host_clr) == '0) |=> alert_n);

  // R8
  eng_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we && host_we && (eng_idx == host_idx) |=> regs[$past(eng_idx)] == $past(eng_data));
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
  import hb_pkg::*;
#(
  parameter int DW          = HB_DW,
  parameter int AW          = HB_AW,
  parameter int IW          = HB_IW,
  parameter int SYNC_STAGES = HB_SYNC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode_i,
  input  logic          cs_a_i,
  input  logic          cs_b_i,
  input  logic          ale_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] bus_a_i,
  output logic [DW-1:0] bus_a_o,
  output logic          bus_a_oe,
  input  logic [DW-1:0] bus_b_i,
  output logic [DW-1:0] bus_b_o,
  output logic          bus_b_oe,
  input  logic          eng_we_i,
  input  logic [IW-1:0] eng_idx_i,
  input  logic [DW-1:0] eng_data_i,
  output logic          alert_n_o
);
  localparam int             NSTB    = 5;
  localparam logic [NSTB-1:0] STB_RST = 5'b00011;
  localparam int             BW      = AW + DW;

  logic [NSTB-1:0] stb_q, stb_p;
  logic [BW-1:0]   bus_q, bus_p;

  hb_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST_VAL(STB_RST)) u_stb_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({cs_a_i, cs_b_i, ale_i, rd_n_i, wr_n_i}),
    .q      (stb_q),
    .q_prev (stb_p)
  );

  hb_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({bus_a_i, bus_b_i}),
    .q      (bus_q),
    .q_prev (bus_p)
  );

  logic [AW-1:0] lat_addr;
  logic          host_we, rd_done;
  logic [IW-1:0] host_idx, rd_done_idx;
  logic [DW-1:0] host_wdata;

  hb_access #(.AW(AW), .DW(DW), .IW(IW)) u_access (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_mode    (bus_mode_i),
    .cs_s        (stb_q[4:3]),
    .cs_p        (stb_p[4:3]),
    .ale_s       (stb_q[2]),
    .ale_p       (stb_p[2]),
    .rd_s        (stb_q[1]),
    .rd_p        (stb_p[1]),
    .wr_s        (stb_q[0]),
    .wr_p        (stb_p[0]),
    .a_s         (bus_q[BW-1:DW]),
    .a_p         (bus_p[BW-1:DW]),
    .b_s         (bus_q[DW-1:0]),
    .b_p         (bus_p[DW-1:0]),
    .lat_addr    (lat_addr),
    .host_we     (host_we),
    .host_idx    (host_idx),
    .host_wdata  (host_wdata),
    .rd_done     (rd_done),
    .rd_done_idx (rd_done_idx)
  );

  // Read path: combinational from the present address source.
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data, rd_val;
  logic          rd_sel;

  assign rd_addr = bus_mode_i ? lat_addr : bus_a_i;

  hb_regbank #(.DW(DW), .IW(IW)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (host_we),
    .host_idx     (host_idx),
    .host_wdata   (host_wdata),
    .host_rd_done (rd_done),
    .host_rd_idx  (rd_done_idx),
    .eng_we       (eng_we_i),
    .eng_idx      (eng_idx_i),
    .eng_data     (eng_data_i),
    .rd_idx       (rd_addr[IW-1:0]),
    .rd_data      (rd_data),
    .alert_n      (alert_n_o)
  );

  assign rd_val   = idx_in_range(rd_addr) ? rd_data : '0;
  assign rd_sel   = cs_a_i && cs_b_i && !rd_n_i;
  assign bus_a_oe = rd_sel && bus_mode_i;
  assign bus_b_oe = rd_sel && !bus_mode_i;
  assign bus_a_o  = rd_val;
  assign bus_b_o  = rd_val;

  // R2
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_b_oe |-> !bus_a_oe && !bus_mode_i);
endmodule

// File: tb/sim_hostbus_regport.sv
module sim_hostbus_regport;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bus_mode, cs_a, cs_b, ale, rd_n, wr_n;
  logic [7:0] bus_a_i, bus_a_o, bus_b_i, bus_b_o;
  logic       bus_a_oe, bus_b_oe, eng_we, alert_n;
  logic [4:0] eng_idx;
  logic [7:0] eng_data;

  hostbus_regport u0 (
    .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .cs_a_i(cs_a), .cs_b_i(cs_b),
    .ale_i(ale), .rd_n_i(rd_n), .wr_n_i(wr_n), .bus_a_i(bus_a_i), .bus_a_o(bus_a_o),
    .bus_a_oe(bus_a_oe), .bus_b_i(bus_b_i), .bus_b_o(bus_b_o), .bus_b_oe(bus_b_oe),
    .eng_we_i(eng_we), .eng_idx_i(eng_idx), .eng_data_i(eng_data), .alert_n_o(alert_n)
  );

  typedef struct { string req; logic [7:0] exp; bit on_b; } rd_item_t;
  rd_item_t   sb_q[$];
  event       rd_ev;
  int         checks = 0, errors = 0;
  logic [7:0] model [32];
  logic [7:0] mux_lat = 8'h00;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_of(input logic [7:0] a);
    return (a < 8'h20) ? model[a[4:0]] : 8'h00;
  endfunction

  // Monitor: pops the expected item when the driver marks a read sample.
  initial begin
    rd_item_t it;
    forever begin
      @(rd_ev);
      it = sb_q.pop_front();
      if (it.on_b) begin
        chk({it.req, " bus_b data"}, bus_b_o, it.exp);
        chk({it.req, " bus_b_oe"}, {7'b0, bus_b_oe}, 8'h01);
        chk({it.req, " bus_a_oe"}, {7'b0, bus_a_oe}, 8'h00);
      end else begin
        chk({it.req, " bus_a data"}, bus_a_o, it.exp);
        chk({it.req, " bus_a_oe"}, {7'b0, bus_a_oe}, 8'h01);
        chk({it.req, " bus_b_oe"}, {7'b0, bus_b_oe}, 8'h00);
      end
    end
  end

  task automatic sep_write(input logic [7:0] a, input logic [7:0] d);
    bus_a_i = a; bus_b_i = d; wr_n = 1'b0;
    tick(4);
    wr_n = 1'b1;
    tick(4);
    if (a < 8'h20 && cs_a && cs_b) model[a[4:0]] = d;
  endtask

  task automatic sep_read(input logic [7:0] a, input string req);
    bus_a_i = a; rd_n = 1'b0;
    tick(2);
    sb_q.push_back('{req, exp_of(a), 1'b1});
    ->rd_ev;
    tick(1);
    rd_n = 1'b1;
    tick(5);
  endtask

  task automatic mux_latch(input logic [7:0] a);
    bus_a_i = a; ale = 1'b1;
    tick(3);
    ale = 1'b0;
    tick(4);
    mux_lat = a;
  endtask

  task automatic mux_wr(input logic [7:0] d);
    bus_a_i = d;
    tick(1);
    wr_n = 1'b0;
    tick(4);
    wr_n = 1'b1;
    tick(4);
    if (mux_lat < 8'h20) model[mux_lat[4:0]] = d;
  endtask

  task automatic mux_read(input string req);
    rd_n = 1'b0;
    tick(2);
    sb_q.push_back('{req, exp_of(mux_lat), 1'b0});
    ->rd_ev;
    tick(1);
    rd_n = 1'b1;
    tick(5);
  endtask

  task automatic eng_wr(input logic [4:0] i, input logic [7:0] d);
    eng_we = 1'b1; eng_idx = i; eng_data = d;
    tick(1);
    eng_we = 1'b0;
    model[i] = d;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    rst_n = 1'b0; bus_mode = 1'b0; cs_a = 1'b1; cs_b = 1'b1; ale = 1'b0;
    rd_n = 1'b1; wr_n = 1'b1; bus_a_i = '0; bus_b_i = '0;
    eng_we = 1'b0; eng_idx = '0; eng_data = '0;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R9 reset state
    chk("R9 alert_n", {7'b0, alert_n}, 8'h01);
    chk("R9 bus_a_oe", {7'b0, bus_a_oe}, 8'h00);
    chk("R9 bus_b_oe", {7'b0, bus_b_oe}, 8'h00);
    sep_read(8'h00, "R9 reg00");
    sep_read(8'h1F, "R9 reg1F");

    // R2 separate style, host write to a status register gives no alert (R6)
    sep_write(8'h03, 8'hA5);
    sep_write(8'h1E, 8'h3C);
    chk("R6 host write no alert", {7'b0, alert_n}, 8'h01);
    sep_read(8'h03, "R2 reg03");
    sep_read(8'h1E, "R2 reg1E");

    // R11 out-of-range address
    sep_write(8'h23, 8'h77);
    sep_read(8'h03, "R11 alias untouched");
    sep_read(8'h23, "R11 out of range");

    // R3 chip selects
    cs_b = 1'b0;
    sep_write(8'h03, 8'h11);
    cs_b = 1'b1;
    tick(3);
    sep_read(8'h03, "R3 deselected write");
    cs_a = 1'b0; bus_a_i = 8'h03; rd_n = 1'b0;
    tick(2);
    chk("R3 bus_b_oe deselected", {7'b0, bus_b_oe}, 8'h00);
    chk("R3 bus_a_oe deselected", {7'b0, bus_a_oe}, 8'h00);
    rd_n = 1'b1; cs_a = 1'b1;
    tick(4);

    // R4 idle enables, R5 old value while wr_n low
    chk("R4 idle bus_b_oe", {7'b0, bus_b_oe}, 8'h00);
    bus_a_i = 8'h03; bus_b_i = 8'hEE; wr_n = 1'b0;
    tick(4);
    chk("R4 write bus_b_oe", {7'b0, bus_b_oe}, 8'h00);
    rd_n = 1'b0;
    tick(2);
    chk("R5 before rise", bus_b_o, 8'hA5);
    rd_n = 1'b1;
    tick(4);
    wr_n = 1'b1;
    tick(4);
    model[3] = 8'hEE;
    sep_read(8'h03, "R5 after rise");

    // R6 / R7 alert behaviour
    eng_wr(5'h0C, 8'h81);
    chk("R6 alert on change", {7'b0, alert_n}, 8'h00);
    eng_wr(5'h1F, 8'h42);
    eng_wr(5'h0D, 8'h00);
    eng_wr(5'h05, 8'h99);
    sep_read(8'h05, "R7 plain reg");
    chk("R7 plain read keeps alert", {7'b0, alert_n}, 8'h00);
    sep_read(8'h0C, "R7 reg0C");
    chk("R7 one pending left", {7'b0, alert_n}, 8'h00);
    sep_read(8'h1F, "R7 reg1F");
    chk("R7 all read", {7'b0, alert_n}, 8'h01);
    eng_wr(5'h0D, 8'h00);
    chk("R6 same value", {7'b0, alert_n}, 8'h01);
    eng_wr(5'h07, 8'h12);
    chk("R6 non-status", {7'b0, alert_n}, 8'h01);

    // R8 same-cycle collision
    bus_a_i = 8'h0D; bus_b_i = 8'h55; wr_n = 1'b0;
    tick(4);
    wr_n = 1'b1;
    tick(2);
    eng_wr(5'h0D, 8'h66);
    tick(3);
    chk("R8 collision alert", {7'b0, alert_n}, 8'h00);
    sep_read(8'h0D, "R8 engine wins");
    chk("R7 cleared after collision read", {7'b0, alert_n}, 8'h01);

    // R1 / R10 multiplexed style
    bus_mode = 1'b1;
    tick(4);
    mux_latch(8'h07);
    mux_wr(8'h5A);
    mux_read("R1 reg07");
    mux_wr(8'hC3);
    mux_read("R10 reused address");
    mux_latch(8'h03);
    mux_read("R1 reg03");
    mux_latch(8'h1E);
    mux_wr(8'h9B);
    chk("R6 mux host write no alert", {7'b0, alert_n}, 8'h01);
    eng_wr(5'h1E, 8'h01);
    chk("R6 mux alert", {7'b0, alert_n}, 8'h00);
    mux_read("R7 mux reg1E");
    chk("R7 mux clear", {7'b0, alert_n}, 8'h01);
    mux_latch(8'h2A);
    mux_wr(8'h44);
    mux_read("R11 mux out of range");

    tick(4);
    finish_run();
  end
endmodule